// File: doc/BRIEF.md
# Two-Way Interprocessor Mailbox with Doorbell Flags

This block lets two processors, called side 0 and side 1, pass short messages to each other. Each side has its own register port with a write strobe, a read strobe, a word address and 16-bit data. The block holds a set of mailboxes. Some mailboxes carry messages from side 0 to side 1 and the rest carry messages the other way. Each mailbox has two data words, A and B. The sending side fills word A first, if it needs it, and then writes word B. Writing word B rings the doorbell: it sets the mailbox's pending flag, and that flag drives a level interrupt toward the receiving side.

The receiver takes the message by reading the words. When it reads word B, the pending flag clears as a side effect. Each side can see only the flags of the mailboxes that interrupt it. A side may write only the mailboxes it sends from. All other accesses have no effect. Read data is combinational in the cycle the read strobe is high. A clearing read takes effect at the clock edge that ends the read.

Top module: `mbx_top`

## Requirements
- R1: After reset, every data word and every flag is 0, both interrupt vectors are 0, and every read returns 0x0000.
- R2: A write by the sending side to word A (word address 2m for mailbox m) stores the value, and the flag is left unchanged.
- R3: A write by the sending side to word B (address 2m+1) stores the value and sets the flag of mailbox m. The flag, and the interrupt it drives, is 1 from the clock edge that ends the write.
- R4: A read of word B by the receiving side returns the stored word and clears the flag at the edge that ends the read. The interrupt is 0 in the following cycle.
- R5: A read of word A by either side, or a read of word B by the sending side, leaves the flag unchanged.
- R6: The flag of mailbox m is at address 2N+m, where N is the total number of mailboxes. A read by the receiving side returns the flag in bit 0 with bits 15:1 zero. A read by the sending side returns 0x0000.
- R7: Writes by the receiving side to either data word of a mailbox, and writes by any side to a flag address, change nothing.
- R8: If the sender writes word B in the same cycle that the receiver reads it, the flag stays 1 and the read returns the old word.
- R9: When the read strobe is low, the port's read data is 0x0000. Addresses at or above 3N read as 0x0000, and writes to them change nothing.
- R10: Mailboxes 0 to N01-1 are sent by side 0. Mailbox m raises irq_to_s1[m]. The remaining mailboxes are sent by side 1, and mailbox m raises irq_to_s0[m-N01].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s0_wr | input | 1 | Side 0 write strobe |
| s0_rd | input | 1 | Side 0 read strobe |
| s0_addr | input | AW (4) | Side 0 word address |
| s0_wdata | input | DW (16) | Side 0 write data |
| s0_rdata | output | DW (16) | Side 0 read data, combinational |
| s1_wr | input | 1 | Side 1 write strobe |
| s1_rd | input | 1 | Side 1 read strobe |
| s1_addr | input | AW (4) | Side 1 word address |
| s1_wdata | input | DW (16) | Side 1 write data |
| s1_rdata | output | DW (16) | Side 1 read data, combinational |
| irq_to_s0 | output | N10 (2) | Level interrupts toward side 0, one per mailbox sent by side 1 |
| irq_to_s1 | output | N01 (2) | Level interrupts toward side 1, one per mailbox sent by side 0 |

## Verification
Two events can fall in the same cycle: a sender's write to word B, which sets the flag, and the receiver's read of that same word, which clears it. The bench provokes this by driving both ports in one cycle, with the sender writing a new word B while the receiver reads it. It then expects three results: the read returns the previous word, the interrupt stays high, and a later receiver read returns the new word and only then clears the flag. A checker also requires that a cycle with both events leaves the flag set. Throughout, each flag may rise only after a set event and fall only after a clear event.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    RK_NONE,
    RK_WORD_A,
    RK_WORD_B,
    RK_FLAG
  } reg_kind_e;

  // Classify a word index within a map of n mailboxes.
  function automatic reg_kind_e kind_of(input int unsigned idx, input int unsigned n);
    if (idx < 2 * n)      return idx[0] ? RK_WORD_B : RK_WORD_A;
    else if (idx < 3 * n) return RK_FLAG;
    else                  return RK_NONE;
  endfunction

  // Mailbox number addressed by a word index (0 when outside the map).
  function automatic int unsigned slot_of(input int unsigned idx, input int unsigned n);
    if (idx < 2 * n)      return idx >> 1;
    else if (idx < 3 * n) return idx - 2 * n;
    else                  return 0;
  endfunction

  // Side that sends on mailbox m: side 0 owns the first n01 mailboxes.
  function automatic logic sender_of(input int unsigned m, input int unsigned n01);
    return (m < n01) ? 1'b0 : 1'b1;
  endfunction

endpackage

// File: rtl/mbx_side_dec.sv
module mbx_side_dec
  import mbx_pkg::*;
#(
  parameter int unsigned N    = 4,
  parameter int unsigned N01  = 2,
  parameter int unsigned AW   = 4,
  parameter bit          SIDE = 1'b0,
  localparam int unsigned SW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  wr_a,
  output logic [N-1:0]  wr_b,
  output logic [N-1:0]  clr,
  output reg_kind_e     kind,
  output logic [SW-1:0] slot,
  output logic          flag_vis
);

  int unsigned idx;
  int unsigned sidx;
  logic        own;

  always_comb begin
    idx      = 32'(addr);
    kind     = kind_of(idx, N);
    sidx     = slot_of(idx, N);
    own      = (sender_of(sidx, N01) == SIDE);
    slot     = SW'(sidx);
    flag_vis = (kind == RK_FLAG) && !own;
    for (int unsigned m = 0; m < N; m++) begin
      wr_a[m] = wr && (kind == RK_WORD_A) && (sidx == m) && own;
      wr_b[m] = wr && (kind == RK_WORD_B) && (sidx == m) && own;
      clr[m]  = rd && (kind == RK_WORD_B) && (sidx == m) && !own;
    end
  end

endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic          clr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] word_a,
  output logic [DW-1:0] word_b,
  output logic          flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_a <= '0;
      word_b <= '0;
      flag   <= 1'b0;
    end else begin
      if (wr_a) word_a <= wdata;
      if (wr_b) word_b <= wdata;
      // Setting has priority over a same-cycle clearing read.
      if (wr_b)     flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

endmodule

// File: rtl/mbx_rd_mux.sv
module mbx_rd_mux
  import mbx_pkg::*;
#(
  parameter int unsigned N   = 4,
  parameter int unsigned DW  = 16,
  localparam int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 rd,
  input  reg_kind_e            kind,
  input  logic [SW-1:0]        slot,
  input  logic                 flag_vis,
  input  logic [N-1:0][DW-1:0] word_a,
  input  logic [N-1:0][DW-1:0] word_b,
  input  logic [N-1:0]         flag,
  output logic [DW-1:0]        rdata
);

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (kind)
        RK_WORD_A: rdata = word_a[slot];
        RK_WORD_B: rdata = word_b[slot];
        RK_FLAG:   if (flag_vis) rdata = {{(DW-1){1'b0}}, flag[slot]};
        default:   rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
#(
  parameter int unsigned N01 = 2,
  parameter int unsigned N10 = 2,
  parameter int unsigned DW  = 16,
  parameter int unsigned AW  = 4,
  localparam int unsigned N  = N01 + N10,
  localparam int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           s0_wr,
  input  logic           s0_rd,
  input  logic [AW-1:0]  s0_addr,
  input  logic [DW-1:0]  s0_wdata,
  output logic [DW-1:0]  s0_rdata,
  input  logic           s1_wr,
  input  logic           s1_rd,
  input  logic [AW-1:0]  s1_addr,
  input  logic [DW-1:0]  s1_wdata,
  output logic [DW-1:0]  s1_rdata,
  output logic [N10-1:0] irq_to_s0,
  output logic [N01-1:0] irq_to_s1
);

  // Decoded per-side strobes
  logic [N-1:0] s0_wr_a, s0_wr_b, s0_clr;
  logic [N-1:0] s1_wr_a, s1_wr_b, s1_clr;
  reg_kind_e     s0_kind, s1_kind;
  logic [SW-1:0] s0_slot, s1_slot;
  logic          s0_fvis, s1_fvis;

  // Named events and state brought out for the checker
  logic [N-1:0]         set_evt;
  logic [N-1:0]         clr_evt;
  logic [N-1:0]         wra_evt;
  logic [N-1:0]         flag_q;
  logic [N-1:0][DW-1:0] word_a;
  logic [N-1:0][DW-1:0] word_b;

  mbx_side_dec #(.N(N), .N01(N01), .AW(AW), .SIDE(1'b0)) u_dec0 (
    .wr(s0_wr), .rd(s0_rd), .addr(s0_addr),
    .wr_a(s0_wr_a), .wr_b(s0_wr_b), .clr(s0_clr),
    .kind(s0_kind), .slot(s0_slot), .flag_vis(s0_fvis)
  );

  mbx_side_dec #(.N(N), .N01(N01), .AW(AW), .SIDE(1'b1)) u_dec1 (
    .wr(s1_wr), .rd(s1_rd), .addr(s1_addr),
    .wr_a(s1_wr_a), .wr_b(s1_wr_b), .clr(s1_clr),
    .kind(s1_kind), .slot(s1_slot), .flag_vis(s1_fvis)
  );

  // Only the owning side's decoder can produce a write strobe for a mailbox,
  // and only the other side's decoder a clearing read.
  assign set_evt = s0_wr_b | s1_wr_b;
  assign wra_evt = s0_wr_a | s1_wr_a;
  assign clr_evt = s0_clr  | s1_clr;

  for (genvar m = 0; m < N; m++) begin : g_slot
    logic [DW-1:0] slot_wdata;
    if (m < N01) begin : g_from0
      assign slot_wdata = s0_wdata;
    end else begin : g_from1
      assign slot_wdata = s1_wdata;
    end

    mbx_slot #(.DW(DW)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_a(wra_evt[m]), .wr_b(set_evt[m]), .clr(clr_evt[m]),
      .wdata(slot_wdata),
      .word_a(word_a[m]), .word_b(word_b[m]), .flag(flag_q[m])
    );
  end

  mbx_rd_mux #(.N(N), .DW(DW)) u_mux0 (
    .rd(s0_rd), .kind(s0_kind), .slot(s0_slot), .flag_vis(s0_fvis),
    .word_a(word_a), .word_b(word_b), .flag(flag_q), .rdata(s0_rdata)
  );

  mbx_rd_mux #(.N(N), .DW(DW)) u_mux1 (
    .rd(s1_rd), .kind(s1_kind), .slot(s1_slot), .flag_vis(s1_fvis),
    .word_a(word_a), .word_b(word_b), .flag(flag_q), .rdata(s1_rdata)
  );

  assign irq_to_s1 = flag_q[N01-1:0];
  assign irq_to_s0 = flag_q[N-1:N01];

endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
  parameter int unsigned N  = 4,
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         set_evt,
  input logic [N-1:0]         clr_evt,
  input logic [N-1:0]         flag_q,
  input logic [N-1:0][DW-1:0] word_b,
  input logic                 s0_rd,
  input logic [AW-1:0]        s0_addr,
  input logic [DW-1:0]        s0_rdata,
  input logic                 s1_rd,
  input logic [AW-1:0]        s1_addr,
  input logic [DW-1:0]        s1_rdata
);

  localparam int unsigned FLO = 2 * N;
  localparam int unsigned FHI = 3 * N;

  for (genvar m = 0; m < N; m++) begin : g_chk
    // R3
    set_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[m] |=> flag_q[m]);
    // R3
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[m]) |-> $past(set_evt[m]));
    // R4
    clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_evt[m] && !set_evt[m]) |=> !flag_q[m]);
    // R4
    fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[m]) |-> $past(clr_evt[m]));
    // R8
    collide_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_evt[m] && set_evt[m]) |=> flag_q[m]);
    // R7
    word_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !set_evt[m] |=> $stable(word_b[m]));
  end

  // R6
  s0_flag_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_rd && 32'(s0_addr) >= FLO && 32'(s0_addr) < FHI) |-> (s0_rdata[DW-1:1] == '0));
  // R6
  s1_flag_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_rd && 32'(s1_addr) >= FLO && 32'(s1_addr) < FHI) |-> (s1_rdata[DW-1:1] == '0));
  // R9
  s0_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s0_rd |-> (s0_rdata == '0));
  // R9
  s1_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_rd |-> (s1_rdata == '0));

endmodule

bind mbx_top mbx_chk #(.N(N), .DW(DW), .AW(AW)) u_chk (.*);

// File: tb/tb_mbx_top.sv
module tb_mbx_top;

  localparam int CLK_P = 10;
  localparam int N01   = 2;
  localparam int N10   = 2;
  localparam int DW    = 16;
  localparam int AW    = 4;
  localparam int N     = N01 + N10;
  localparam int NADDR = 1 << AW;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           s0_wr, s0_rd, s1_wr, s1_rd;
  logic [AW-1:0]  s0_addr, s1_addr;
  logic [DW-1:0]  s0_wdata, s1_wdata, s0_rdata, s1_rdata;
  logic [N10-1:0] irq_to_s0;
  logic [N01-1:0] irq_to_s1;

  int n_run  = 0;
  int n_fail = 0;

  logic [DW-1:0] ea [N];
  logic [DW-1:0] eb [N];
  logic          ef [N];

  always #(CLK_P/2) clk = ~clk;

  mbx_top #(.N01(N01), .N10(N10), .DW(DW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .s0_wr(s0_wr), .s0_rd(s0_rd), .s0_addr(s0_addr), .s0_wdata(s0_wdata), .s0_rdata(s0_rdata),
    .s1_wr(s1_wr), .s1_rd(s1_rd), .s1_addr(s1_addr), .s1_wdata(s1_wdata), .s1_rdata(s1_rdata),
    .irq_to_s0(irq_to_s0), .irq_to_s1(irq_to_s1)
  );

  function automatic int sender(input int m);
    return (m < N01) ? 0 : 1;
  endfunction

  function automatic logic [DW-1:0] model_rd(input int side, input int a);
    if (a < 2 * N) return a[0] ? eb[a / 2] : ea[a / 2];
    if (a < 3 * N) return (sender(a - 2 * N) != side) ? {{(DW-1){1'b0}}, ef[a - 2 * N]} : '0;
    return '0;
  endfunction

  function automatic string tag_of(input int a);
    if (a < 2 * N) return "R2 R7 data";
    if (a < 3 * N) return "R6 flag";
    return "R9 unmapped";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_irq(input string req);
    logic [N01-1:0] e1;
    logic [N10-1:0] e0;
    for (int m = 0; m < N01; m++) e1[m] = ef[m];
    for (int m = 0; m < N10; m++) e0[m] = ef[N01 + m];
    check({req, " irq_to_s1"}, 32'(irq_to_s1), 32'(e1));
    check({req, " irq_to_s0"}, 32'(irq_to_s0), 32'(e0));
  endtask

  task automatic model_clr(input int side, input int a);
    if (a < 2 * N && a[0] && sender(a / 2) != side) ef[a / 2] = 1'b0;
  endtask

  task automatic model_wr(input int side, input int a, input logic [DW-1:0] d);
    if (a < 2 * N && sender(a / 2) == side) begin
      if (a[0]) begin eb[a / 2] = d; ef[a / 2] = 1'b1; end
      else        ea[a / 2] = d;
    end
  endtask

  task automatic idle();
    s0_wr = 0; s0_rd = 0; s0_addr = '0; s0_wdata = '0;
    s1_wr = 0; s1_rd = 0; s1_addr = '0; s1_wdata = '0;
  endtask

  // One bus cycle on both ports; read data is checked against the model state.
  task automatic cyc(input logic w0, input logic r0, input int a0, input logic [DW-1:0] d0,
                     input logic w1, input logic r1, input int a1, input logic [DW-1:0] d1);
    logic [DW-1:0] g0, g1;
    @(negedge clk);
    s0_wr = w0; s0_rd = r0; s0_addr = AW'(a0); s0_wdata = d0;
    s1_wr = w1; s1_rd = r1; s1_addr = AW'(a1); s1_wdata = d1;
    #1;
    g0 = s0_rdata;
    g1 = s1_rdata;
    check(r0 ? tag_of(a0) : "R9 idle s0", 32'(g0), r0 ? 32'(model_rd(0, a0)) : 32'h0);
    check(r1 ? tag_of(a1) : "R9 idle s1", 32'(g1), r1 ? 32'(model_rd(1, a1)) : 32'h0);
    if (r0) model_clr(0, a0);
    if (r1) model_clr(1, a1);
    if (w0) model_wr(0, a0, d0);
    if (w1) model_wr(1, a1, d1);
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic acc(input int side, input logic w, input logic r, input int a, input logic [DW-1:0] d);
    if (side == 0) cyc(w, r, a, d, 1'b0, 1'b0, 0, '0);
    else           cyc(1'b0, 1'b0, 0, '0, w, r, a, d);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int m = 0; m < N; m++) begin ea[m] = '0; eb[m] = '0; ef[m] = 1'b0; end
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state on both ports and both interrupt vectors
    chk_irq("R1");
    for (int a = 0; a < NADDR; a++) begin
      cyc(1'b0, 1'b1, a, '0, 1'b0, 1'b1, a, '0);
      check("R1 reset read s0", 32'(model_rd(0, a)), 32'h0);
    end

    // R2: word A does not ring the doorbell
    acc(0, 1'b1, 1'b0, 0, 16'h1234);
    chk_irq("R2");
    // R3: word B rings it
    acc(0, 1'b1, 1'b0, 1, 16'hABCD);
    chk_irq("R3");
    check("R3 irq_to_s1 bit0", 32'(irq_to_s1[0]), 32'h1);
    // R6: flag seen by receiver only
    acc(0, 1'b0, 1'b1, 2 * N, '0);
    acc(1, 1'b0, 1'b1, 2 * N, '0);
    // R7: receiver and flag writes ignored
    acc(1, 1'b1, 1'b0, 0, 16'hFFFF);
    acc(1, 1'b1, 1'b0, 1, 16'hFFFF);
    acc(1, 1'b1, 1'b0, 2 * N, 16'h0000);
    acc(0, 1'b1, 1'b0, 2 * N, 16'h0000);
    chk_irq("R7");
    acc(1, 1'b0, 1'b1, 0, '0);
    // R5: non-clearing reads
    acc(0, 1'b0, 1'b1, 1, '0);
    chk_irq("R5 sender read B");
    acc(1, 1'b0, 1'b1, 0, '0);
    chk_irq("R5 receiver read A");
    // R4: receiver read of B clears
    acc(1, 1'b0, 1'b1, 1, '0);
    chk_irq("R4");
    check("R4 irq_to_s1 bit0", 32'(irq_to_s1[0]), 32'h0);

    // R10: opposite direction, mailbox N01
    acc(1, 1'b1, 1'b0, 2 * N01 + 1, 16'h5A5A);
    check("R10 irq_to_s0 bit0", 32'(irq_to_s0[0]), 32'h1);
    chk_irq("R10");
    acc(1, 1'b0, 1'b1, 2 * N01 + 1, '0);
    chk_irq("R5 R10 sender read");
    acc(0, 1'b0, 1'b1, 2 * N + N01, '0);
    acc(0, 1'b0, 1'b1, 2 * N01 + 1, '0);
    chk_irq("R4 R10");

    // R8: set and clear in one cycle on the last mailbox
    acc(1, 1'b1, 1'b0, 2 * N - 1, 16'h1111);
    cyc(1'b0, 1'b1, 2 * N - 1, '0, 1'b1, 1'b0, 2 * N - 1, 16'h2222);
    check("R8 flag kept", 32'(irq_to_s0[N10-1]), 32'h1);
    chk_irq("R8");
    acc(0, 1'b0, 1'b1, 2 * N - 1, '0);
    chk_irq("R8 later clear");

    // R9: unmapped addresses and idle strobes
    acc(0, 1'b1, 1'b0, NADDR - 1, 16'hBEEF);
    acc(1, 1'b1, 1'b0, NADDR - 1, 16'hBEEF);
    acc(0, 1'b0, 1'b1, NADDR - 1, '0);
    acc(1, 1'b0, 1'b0, 1, '0);
    chk_irq("R9");

    // Sweep: every side writes every address, then both sides read everything.
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < NADDR; a++) begin
        acc(s, 1'b1, 1'b0, a, DW'((s + 1) * 16'h0F31 ^ (a * 16'h0101)));
        chk_irq("R3 R10 sweep");
        for (int rs = 0; rs < 2; rs++)
          for (int ra = 0; ra < NADDR; ra++)
            acc(rs, 1'b0, 1'b1, ra, '0);
        chk_irq("R4 sweep");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule